// File: doc/BRIEF.md
# Word-Wide One-Time-Programmable Memory Model

This block is a clocked, synthesizable stand-in for a 16-bit-wide one-time-programmable word memory. It is meant for system models and emulation setups that need a behaving boot store. Each clock edge samples the active-low chip enable, output enable and program strobe. It also samples two flags: one marks the programming supply as present, the other marks a high voltage on address bit 9. From these inputs it decodes read, verify, program, output disable, standby, program inhibit and an identification mode. Identification mode returns a fixed manufacturer word or device word in place of array data.

The array starts erased, with every bit at one. A program cycle can only clear bits: the new word is the old word ANDed with the input data. The bidirectional data pins are split into a data input, a registered data output and an output-enable flag. A separate valid flag models access time as two cycle counts. One count applies after an address change or chip enable going low. The other, shorter count applies after output enable going low. The address port is 17 bits wide. The backing store holds a parameterized number of words, and it is indexed by the low address bits.

Top module: `otp_word_mem`

## Requirements
- R1: While reset is asserted and after it is released, dataOutEn, dataValid and dataOut are 0, and every stored word reads back as 16'hFFFF until it is programmed.
- R2: When ceN and oeN are both sampled low and identification is not selected, the next edge sets dataOutEn to 1 and loads dataOut with the word stored at addrIn modulo the store depth.
- R3: When ceN or oeN is sampled high (standby, output disable, program or inhibit), the next edge clears dataOutEn, and dataOut reads 0 whenever dataOutEn is 0.
- R4: With ceN low, oeN high, pgmN low and vppOn high, the edge writes the addressed word, and the write is visible to a read on the next cycle.
- R5: No write takes place if vppOn is low, if pgmN is high, or if ceN is high (inhibit); the word reads back unchanged afterwards.
- R6: With ceN and oeN low, pgmN high and vppOn high (verify), the stored word is driven just as in a read.
- R7: When ceN and oeN are low, hvA9 is high and every address bit other than bits 0 and 9 is 0, dataOut is 16'h001E if addrIn[0] is 0 and 16'h00F7 if it is 1. When any other address bit is set, a normal read takes place.
- R8: A program cycle stores the old word ANDed with dataIn, so a bit once cleared stays 0.
- R9: dataValid rises exactly ADDR_LAT edges after the edge that first samples a new addrIn value, a new hvA9 value, or ceN low, provided the word is being driven and output enable has settled.
- R10: dataValid rises exactly OE_LAT edges after the edge that first samples oeN low, provided the address has settled.
- R11: dataValid implies dataOutEn. When ADDR_LAT is not 0, dataValid is 0 after any edge at which addrIn differs from its previous sample.
- R12: Addresses that are equal modulo the store depth (64 words by default) refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; erases the store |
| addrIn | input | 17 | Word address |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| pgmN | input | 1 | Program strobe, active low |
| vppOn | input | 1 | Programming supply present |
| hvA9 | input | 1 | High voltage present on address bit 9 |
| dataIn | input | 16 | Word to program |
| dataOut | output | 16 | Registered output word, 0 when not driven |
| dataOutEn | output | 1 | Output drivers enabled |
| dataValid | output | 1 | Output word has met its access latency |

## Verification
A wrong write-enable decode shows up as stale or corrupted read data on the cycle after the next read of that word. This is why every program attempt in the bench is followed at once by a read of the same address. A mode decoder stuck in the wrong state shows at dataOutEn on the very next edge. A wrong identification decode shows as array data in place of the fixed codes. A miscounted age counter moves the dataValid edge by one or more cycles. The bench therefore samples dataValid after each edge of both latency windows, not only at the end.

// File: rtl/otp_word_pkg.sv
package otp_word_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_INHIBIT,
    MODE_DISABLE,
    MODE_PROGRAM,
    MODE_READ,
    MODE_VERIFY,
    MODE_IDENT
  } otp_mode_e;

  // strobes from control to datapath, valid for the coming edge
  typedef struct packed {
    logic wrEn;
    logic drive;
    logic selId;
  } otp_strobe_t;

  localparam logic [15:0] ID_MAKER = 16'h001E;
  localparam logic [15:0] ID_PART  = 16'h00F7;

endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_word_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int ADDR_LAT = 3,
  parameter int OE_LAT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              vppOn,
  input  logic              hvA9,
  output otp_strobe_t       strb,
  output logic              dataOutEn,
  output logic              dataValid
);

  localparam int ACW = $clog2(ADDR_LAT + 1) + 1;
  localparam int OCW = $clog2(OE_LAT + 1) + 1;
  localparam logic [ACW-1:0] A_LIM = ACW'(ADDR_LAT);
  localparam logic [OCW-1:0] O_LIM = OCW'(OE_LAT);
  // identification ignores bit 0 (code select) and bit 9 (high-voltage pin)
  localparam logic [ADDR_W-1:0] ID_CARE = ~(ADDR_W'(1) | (ADDR_W'(1) << 9));

  otp_mode_e mode;
  logic idSel;

  logic [ADDR_W-1:0] addrHeld;
  logic ceHeld, oeHeld, hvHeld;
  logic [ACW-1:0] addrAge;
  logic [OCW-1:0] oeAge;
  logic addrRestart, oeRestart;

  always_comb begin
    idSel = hvA9 && ((addrIn & ID_CARE) == '0);
    if (ceN)
      mode = vppOn ? MODE_INHIBIT : MODE_STANDBY;
    else if (oeN)
      mode = (vppOn && !pgmN) ? MODE_PROGRAM : MODE_DISABLE;
    else if (idSel)
      mode = MODE_IDENT;
    else if (vppOn && pgmN)
      mode = MODE_VERIFY;
    else
      mode = MODE_READ;
  end

  always_comb begin
    strb.wrEn  = (mode == MODE_PROGRAM);
    strb.drive = (mode == MODE_READ) || (mode == MODE_VERIFY) || (mode == MODE_IDENT);
    strb.selId = (mode == MODE_IDENT);
  end

  assign addrRestart = ceN || ceHeld || (addrIn != addrHeld) || (hvA9 != hvHeld);
  assign oeRestart   = oeN || oeHeld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrHeld  <= '0;
      ceHeld    <= 1'b1;
      oeHeld    <= 1'b1;
      hvHeld    <= 1'b0;
      addrAge   <= '0;
      oeAge     <= '0;
      dataOutEn <= 1'b0;
    end else begin
      addrHeld  <= addrIn;
      ceHeld    <= ceN;
      oeHeld    <= oeN;
      hvHeld    <= hvA9;
      dataOutEn <= strb.drive;
      if (addrRestart)
        addrAge <= '0;
      else if (addrAge < A_LIM)
        addrAge <= addrAge + ACW'(1);
      if (oeRestart)
        oeAge <= '0;
      else if (oeAge < O_LIM)
        oeAge <= oeAge + OCW'(1);
    end
  end

  assign dataValid = dataOutEn && (addrAge >= A_LIM) && (oeAge >= O_LIM);

endmodule

// File: rtl/otp_datapath.sv
module otp_datapath
  import otp_word_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int STORE_AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STORE_AW-1:0] wordIdx,
  input  logic [DATA_W-1:0]   dataIn,
  input  otp_strobe_t         strb,
  output logic [DATA_W-1:0]   dataOut
);

  localparam int DEPTH = 1 << STORE_AW;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] idWord;

  assign idWord = wordIdx[0] ? DATA_W'(ID_PART) : DATA_W'(ID_MAKER);

  // cells only move from 1 to 0: a write ANDs the new pattern in
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (strb.wrEn) begin
      cells[wordIdx] <= cells[wordIdx] & dataIn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dataOut <= '0;
    else if (strb.drive)
      dataOut <= strb.selId ? idWord : cells[wordIdx];
    else
      dataOut <= '0;
  end

endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
  import otp_word_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int STORE_AW = 6,
  parameter int ADDR_LAT = 3,
  parameter int OE_LAT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              vppOn,
  input  logic              hvA9,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              dataValid
);

  otp_strobe_t strb;

  otp_ctrl #(
    .ADDR_W  (ADDR_W),
    .ADDR_LAT(ADDR_LAT),
    .OE_LAT  (OE_LAT)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addrIn   (addrIn),
    .ceN      (ceN),
    .oeN      (oeN),
    .pgmN     (pgmN),
    .vppOn    (vppOn),
    .hvA9     (hvA9),
    .strb     (strb),
    .dataOutEn(dataOutEn),
    .dataValid(dataValid)
  );

  otp_datapath #(
    .DATA_W  (DATA_W),
    .STORE_AW(STORE_AW)
  ) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wordIdx(addrIn[STORE_AW-1:0]),
    .dataIn (dataIn),
    .strb   (strb),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/otp_word_mem_chk.sv
module otp_word_mem_chk
  import otp_word_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int ADDR_LAT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addrIn,
  input logic              ceN,
  input logic              oeN,
  input logic              hvA9,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn,
  input logic              dataValid
);

  localparam logic [ADDR_W-1:0] ID_CARE = ~(ADDR_W'(1) | (ADDR_W'(1) << 9));

  p_valid_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> dataOutEn);

  p_float_on_enable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ceN || oeN) |=> !dataOutEn);

  p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dataOutEn |-> (dataOut == '0));

  p_drive_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceN && !oeN) |=> dataOutEn);

  p_ident_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceN && !oeN && hvA9 && ((addrIn & ID_CARE) == '0)) |=>
      (dataOut == ($past(addrIn[0]) ? DATA_W'(ID_PART) : DATA_W'(ID_MAKER))));

  generate
    if (ADDR_LAT > 0) begin : g_addr_lat
      p_addr_change_drops_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addrIn) |=> !dataValid);
    end
  endgenerate

endmodule

bind otp_word_mem otp_word_mem_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .ADDR_LAT(ADDR_LAT)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .addrIn   (addrIn),
  .ceN      (ceN),
  .oeN      (oeN),
  .hvA9     (hvA9),
  .dataOut  (dataOut),
  .dataOutEn(dataOutEn),
  .dataValid(dataValid)
);

// File: tb/otp_word_mem_tb.sv
`timescale 1ns/1ps
module otp_word_mem_tb_top;

  localparam int ADDR_W   = 17;
  localparam int DATA_W   = 16;
  localparam int STORE_AW = 6;
  localparam int ADDR_LAT = 3;
  localparam int OE_LAT   = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic ceN = 1'b1, oeN = 1'b1, pgmN = 1'b1, vppOn = 1'b0, hvA9 = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic dataOutEn, dataValid;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  otp_word_mem #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_AW(STORE_AW),
    .ADDR_LAT(ADDR_LAT), .OE_LAT(OE_LAT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .ceN(ceN), .oeN(oeN),
    .pgmN(pgmN), .vppOn(vppOn), .hvA9(hvA9), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .dataValid(dataValid)
  );

  typedef struct packed {
    logic [16:0] addr;
    logic        ceN;
    logic        oeN;
    logic        pgmN;
    logic        vpp;
    logic        hv;
    logic [15:0] din;
    logic        expEn;
    logic [15:0] expOut;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{17'h00005, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hFFFF, 8'd1 },  // R1 erased read
    '{17'h00005, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h12F0, 1'b0, 16'h0000, 8'd4 },  // R4 program
    '{17'h00005, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h12F0, 8'd4 },  // R4 readback
    '{17'h00005, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'hFF0F, 1'b0, 16'h0000, 8'd8 },  // R8 second program
    '{17'h00005, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h1200, 8'd6 },  // R6 verify, R8 AND
    '{17'h00007, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd5 },  // R5 no supply
    '{17'h00007, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hFFFF, 8'd5 },
    '{17'h00007, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd5 },  // R5 inhibit
    '{17'h00007, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hFFFF, 8'd5 },
    '{17'h00007, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd5 },  // R5 strobe high
    '{17'h00007, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hFFFF, 8'd5 },
    '{17'h00007, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd3 },  // R3 output disable
    '{17'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h001E, 8'd7 },  // R7 maker code
    '{17'h00001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h00F7, 8'd7 },  // R7 part code
    '{17'h00201, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h00F7, 8'd7 },  // R7 bit 9 ignored
    '{17'h00005, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h1200, 8'd7 },  // R7 other bit set
    '{17'h00049, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'hA5A5, 1'b0, 16'h0000, 8'd12},  // R12 program alias
    '{17'h00009, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hA5A5, 8'd12},
    '{17'h10009, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hA5A5, 8'd12},
    '{17'h00009, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd3 }   // R3 standby
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [16:0] a, input logic ce, input logic oe,
                      input logic pg, input logic vp, input logic hv, input logic [15:0] d);
    addrIn = a; ceN = ce; oeN = oe; pgmN = pg; vppOn = vp; hvA9 = hv; dataIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    #400000;
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 dataOutEn in reset", 32'(dataOutEn), 0);
    chk("R1 dataValid in reset", 32'(dataValid), 0);
    chk("R1 dataOut in reset", 32'(dataOut), 0);
    rst_n = 1'b1;
    step(17'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R1 dataOutEn after reset", 32'(dataOutEn), 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].addr, VEC[i].ceN, VEC[i].oeN, VEC[i].pgmN, VEC[i].vpp, VEC[i].hv, VEC[i].din);
      chk($sformatf("R%0d vec %0d dataOutEn", VEC[i].req, i), 32'(dataOutEn), 32'(VEC[i].expEn));
      chk($sformatf("R%0d vec %0d dataOut", VEC[i].req, i), 32'(dataOut), 32'(VEC[i].expOut));
    end

    // R9: chip enable low restarts address age
    step(17'h5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R9 valid at edge 0 after CE low", 32'(dataValid), 0);
    step(17'h5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R9 valid at edge 1", 32'(dataValid), 0);
    step(17'h5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R9 valid at edge 2", 32'(dataValid), 0);
    step(17'h5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R9 valid at edge 3", 32'(dataValid), 1);
    chk("R2 data when valid", 32'(dataOut), 32'h1200);

    // R11 / R9: address change
    step(17'h9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R11 valid drops on address change", 32'(dataValid), 0);
    chk("R2 new address data", 32'(dataOut), 32'hA5A5);
    step(17'h9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R9 valid 1 edge after addr", 32'(dataValid), 0);
    step(17'h9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R9 valid 2 edges after addr", 32'(dataValid), 0);
    step(17'h9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R9 valid 3 edges after addr", 32'(dataValid), 1);

    // R10: output enable latency with address settled
    step(17'h9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R3 float on OE high", 32'(dataOutEn), 0);
    chk("R10 valid low while OE high", 32'(dataValid), 0);
    step(17'h9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R10 drive on first OE low edge", 32'(dataOutEn), 1);
    chk("R10 valid at OE edge 0", 32'(dataValid), 0);
    step(17'h9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R10 valid at OE edge 1", 32'(dataValid), 1);
    chk("R10 data", 32'(dataOut), 32'hA5A5);

    finish_run();
  end

endmodule